// File: doc/BRIEF.md
# Serial Controller FIFO Status and Interrupt Unit

This unit holds the two byte queues of a serial bus controller. One queue carries bytes from software to the transaction engine, and the other carries bytes back. The unit also holds a separate level threshold for each queue. Each queue has a flush control that clears itself when the flush finishes. A four-register interrupt block sits on top: raw status, enable mask, masked status and a write-one-to-clear port. Software reaches all of this through a simple register bus with read and write strobes. The transaction engine pops the transmit queue and pushes the receive queue directly. The engine also raises one-cycle event pulses: transaction done, arbitration lost, bus error and slave-side requests.

The status bits are of two kinds, and the unit keeps them apart. Queue condition bits follow the queue levels on every cycle and cannot be written. Event bits are sticky: once set they stay set until software clears them. The single interrupt line is high whenever any enabled status bit is set.

Each queue has its own flush state machine with two states, `FL_IDLE` and `FL_RUN`. The transition `FL_IDLE -> FL_RUN` happens when a control write sets that queue's flush bit. The transition `FL_RUN -> FL_IDLE` happens after `FLUSH_CYC` cycles in `FL_RUN`. While in `FL_RUN`, the queue level is held at zero and the control bit reads back as one.

Register map (4-bit address): 0 control, 1 transmit data (write), 2 receive data (read), 3 transmit threshold, 4 receive threshold, 5 mask, 6 raw status, 7 masked status, 8 clear.

Top module: `sio_fifo_irq`

## Requirements
- R1: After reset, both queues are empty and both thresholds are zero. The mask is zero, the control register reads 0, the interrupt line is low, and raw status reads 0x00000033 (bits 0, 1, 4 and 5 set).
- R2: Each queue is 16 entries deep and first-in first-out. A write to address 1 pushes its low byte, and `tx_byte` shows the oldest byte, which `tx_pop` removes. An `rx_push` stores `rx_byte`, and a read of address 2 returns the oldest byte in bits 7:0 and removes it.
- R3: Raw bit 0 is set when the transmit queue is empty and bit 2 when it holds 16 bytes. Raw bit 4 is set when the receive queue is empty and bit 6 when it holds 16 bytes.
- R4: Raw bit 1 (transmit nearly empty) is set while the transmit level is less than or equal to the transmit threshold.
- R5: Raw bit 5 (receive nearly full) is set while the receive level is greater than or equal to the receive threshold.
- R6: The thresholds at addresses 3 and 4 are 4 bits wide, so the largest value is 15. A write keeps the low 4 bits, and a read returns them zero-extended.
- R7: A write to address 1 while the transmit queue is full sets sticky raw bit 3 (overrun). The byte is dropped and the queue contents are unchanged.
- R8: An `eng_evt` pulse on bit 16, 17, 18, 19, 20, 24, 25 or 28 sets the same raw bit, and that bit stays set. Pulses on any other `eng_evt` bit have no effect.
- R9: Writing ones to address 8 clears sticky bits only where the written value has a one inside 0x131F007F. Queue condition bits are not changed by clear writes. If an event sets a bit in the same cycle that a clear write clears it, the bit ends up set.
- R10: The mask at address 5 stores bits 28:0, and bits 31:29 always read as zero. Masked status at address 7 equals raw AND mask, and `irq` is high exactly when masked status is nonzero.
- R11: Writing a one to control bit 7 (transmit) or bit 8 (receive) starts a flush of that queue. The bit reads 1 for the 4 cycles that follow the write and then returns to 0 by itself.
- R12: From the flush write until the flush ends, the queue level is zero and pushes and pops on that queue are ignored. The queue is empty when the flush ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 2 pops the receive queue |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| tx_pop | input | 1 | Engine removes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Engine stores a received byte |
| rx_byte | input | 8 | Received byte from the engine |
| eng_evt | input | 32 | One-cycle event pulses from the transaction engine |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situations to reach from the ports are the ones where two things happen in the same cycle. One is an event pulse arriving in the very cycle that software writes a clear for the same bit. The other is a push arriving while a flush is holding the queue at zero. The bench drives the strobes and engine pulses together by hand for these cases. It also follows the control bit cycle by cycle from the flush write, to confirm that the flush lasts exactly four cycles. Random operations with a fixed seed fill the queues past full and sweep the thresholds across the current levels. Random mask, clear and event words are mixed in, and after each operation the bench compares the raw and masked status against its own model.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_TXDATA = 4'd1;
    localparam logic [ADDR_W-1:0] A_RXDATA = 4'd2;
    localparam logic [ADDR_W-1:0] A_TXTHR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_RXTHR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd5;
    localparam logic [ADDR_W-1:0] A_RAW    = 4'd6;
    localparam logic [ADDR_W-1:0] A_MSTAT  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 4'd8;

    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_LOW   = 1;
    localparam int B_TX_FULL  = 2;
    localparam int B_TX_OVR   = 3;
    localparam int B_RX_EMPTY = 4;
    localparam int B_RX_HIGH  = 5;
    localparam int B_RX_FULL  = 6;

    localparam int C_TX_FLUSH = 7;
    localparam int C_RX_FLUSH = 8;

    localparam logic [DATA_W-1:0] CLEARABLE  = 32'h131F_007F;
    localparam logic [DATA_W-1:0] ENG_EVENTS = 32'h131F_0000;
    localparam logic [DATA_W-1:0] STICKY     = 32'h131F_0008;
    localparam logic [DATA_W-1:0] MASK_RW    = 32'h1FFF_FFFF;

    typedef enum logic {
        FL_IDLE,
        FL_RUN
    } flush_state_e;

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo
    import sio_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WIDTH     = 8,
    parameter int FLUSH_CYC = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_req,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH):0]       level,
    output logic                         busy
);

    localparam int PW = $clog2(DEPTH);
    localparam int LW = PW + 1;
    localparam int CW = $clog2(FLUSH_CYC) + 1;

    flush_state_e   state_q, state_d;
    logic [CW-1:0]  fl_cnt;
    logic           hold_zero;
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [WIDTH-1:0] mem [DEPTH];
    logic           do_push, do_pop;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (flush_req) state_d = FL_RUN;
            FL_RUN:  if (fl_cnt == CW'(FLUSH_CYC - 1)) state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            fl_cnt  <= '0;
        end else begin
            state_q <= state_d;
            fl_cnt  <= (state_q == FL_RUN) ? fl_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        busy      = 1'b0;
        hold_zero = 1'b0;
        unique case (state_q)
            FL_IDLE: hold_zero = flush_req;
            FL_RUN: begin
                busy      = 1'b1;
                hold_zero = 1'b1;
            end
        endcase
    end

    assign do_push = push && !hold_zero && (level < LW'(DEPTH));
    assign do_pop  = pop && !hold_zero && (level != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (hold_zero) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] level_bits,
    input  logic [DATA_W-1:0] set_bits,
    input  logic              mask_we,
    input  logic              clear_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] masked,
    output logic              irq
);

    logic [DATA_W-1:0] sticky_q;
    logic [DATA_W-1:0] clr_vec;

    assign clr_vec = clear_we ? (wdata & CLEARABLE) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
            mask_q   <= '0;
        end else begin
            sticky_q <= ((sticky_q & ~clr_vec) | set_bits) & STICKY;
            if (mask_we) mask_q <= wdata & MASK_RW;
        end
    end

    assign raw    = sticky_q | (level_bits & ~STICKY);
    assign masked = raw & mask_q;
    assign irq    = |masked;

endmodule

// File: rtl/sio_fifo_irq.sv
module sio_fifo_irq
    import sio_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int FLUSH_CYC = 4,
    parameter int THR_MAX   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic [31:0]       eng_evt,
    output logic              irq
);

    localparam int LW  = $clog2(DEPTH) + 1;
    localparam int THW = $clog2(THR_MAX + 1);

    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_busy, rx_busy;
    logic [7:0]        rx_head;
    logic [THW-1:0]    tx_thr, rx_thr;
    logic [DATA_W-1:0] level_bits, set_bits, raw_st, mask_q, masked_st;
    logic              tx_wr, rx_rd, tx_ovr;

    assign tx_wr  = reg_wr && (reg_addr == A_TXDATA);
    assign rx_rd  = reg_rd && (reg_addr == A_RXDATA);
    assign tx_ovr = tx_wr && !tx_busy && (tx_level == LW'(DEPTH));

    sio_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8), .FLUSH_CYC(FLUSH_CYC)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (reg_wr && (reg_addr == A_CTRL) && reg_wdata[C_TX_FLUSH]),
        .push      (tx_wr),
        .din       (reg_wdata[7:0]),
        .pop       (tx_pop),
        .dout      (tx_byte),
        .level     (tx_level),
        .busy      (tx_busy)
    );

    sio_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8), .FLUSH_CYC(FLUSH_CYC)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (reg_wr && (reg_addr == A_CTRL) && reg_wdata[C_RX_FLUSH]),
        .push      (rx_push),
        .din       (rx_byte),
        .pop       (rx_rd),
        .dout      (rx_head),
        .level     (rx_level),
        .busy      (rx_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_TXTHR) tx_thr <= reg_wdata[THW-1:0];
            if (reg_addr == A_RXTHR) rx_thr <= reg_wdata[THW-1:0];
        end
    end

    always_comb begin
        level_bits             = '0;
        level_bits[B_TX_EMPTY] = (tx_level == '0);
        level_bits[B_TX_LOW]   = (tx_level <= LW'(tx_thr));
        level_bits[B_TX_FULL]  = (tx_level == LW'(DEPTH));
        level_bits[B_RX_EMPTY] = (rx_level == '0);
        level_bits[B_RX_HIGH]  = (rx_level >= LW'(rx_thr));
        level_bits[B_RX_FULL]  = (rx_level == LW'(DEPTH));
        set_bits               = eng_evt & ENG_EVENTS;
        set_bits[B_TX_OVR]     = tx_ovr;
    end

    sio_irq_regs u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_bits (level_bits),
        .set_bits   (set_bits),
        .mask_we    (reg_wr && (reg_addr == A_MASK)),
        .clear_we   (reg_wr && (reg_addr == A_CLEAR)),
        .wdata      (reg_wdata),
        .raw        (raw_st),
        .mask_q     (mask_q),
        .masked     (masked_st),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_TX_FLUSH] = tx_busy;
                reg_rdata[C_RX_FLUSH] = rx_busy;
            end
            A_RXDATA: reg_rdata[7:0]     = rx_head;
            A_TXTHR:  reg_rdata[THW-1:0] = tx_thr;
            A_RXTHR:  reg_rdata[THW-1:0] = rx_thr;
            A_MASK:   reg_rdata          = mask_q;
            A_RAW:    reg_rdata          = raw_st;
            A_MSTAT:  reg_rdata          = masked_st;
            default:  reg_rdata          = '0;
        endcase
    end

endmodule

// File: rtl/sio_fifo_irq_chk.sv
module sio_fifo_irq_chk
    import sio_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int FLUSH_CYC = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr,
    input logic                      reg_rd,
    input logic [3:0]                reg_addr,
    input logic [31:0]               reg_wdata,
    input logic [31:0]               reg_rdata,
    input logic                      irq,
    input logic                      tx_busy,
    input logic [$clog2(DEPTH):0]    tx_level,
    input logic [31:0]               raw,
    input logic [31:0]               mask
);

    localparam int LW = $clog2(DEPTH) + 1;

    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_run <= '0;
        else if (tx_busy) busy_run <= busy_run + 1'b1;
        else              busy_run <= '0;
    end

    AST_FLUSH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) busy_run <= 8'(FLUSH_CYC)); // R11

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_busy |-> (tx_level == '0)); // R12

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_level <= LW'(DEPTH)); // R3

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXDATA && !tx_busy && tx_level == LW'(DEPTH)) |=> raw[B_TX_OVR]); // R7

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[B_TX_OVR] && !(reg_wr && reg_addr == A_CLEAR && reg_wdata[B_TX_OVR])) |=> raw[B_TX_OVR]); // R9

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mask == '0) |-> !irq); // R10

    AST_MASK_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_MASK) |-> (reg_rdata[31:29] == 3'b000)); // R10

endmodule

bind sio_fifo_irq sio_fifo_irq_chk #(.DEPTH(DEPTH), .FLUSH_CYC(FLUSH_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .tx_busy   (tx_busy),
    .tx_level  (tx_level),
    .raw       (raw_st),
    .mask      (mask_q)
);

// File: tb/sim_sio_fifo_irq.sv
`timescale 1ns/1ps
module sim_sio_fifo_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] eng_evt = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    int unsigned txq[$];
    int unsigned rxq[$];
    logic [3:0]  m_txthr = '0, m_rxthr = '0;
    logic [31:0] m_mask = '0, m_sticky = '0;

    localparam logic [31:0] ENG = 32'h131F_0000;
    localparam logic [31:0] CLR = 32'h131F_007F;

    always #2 clk = ~clk;

    sio_fifo_irq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte), .eng_evt(eng_evt), .irq(irq)
    );

    function automatic logic [31:0] exp_raw();
        logic [31:0] r = m_sticky;
        r[0] = (txq.size() == 0);
        r[1] = (txq.size() <= int'(m_txthr));
        r[2] = (txq.size() == 16);
        r[4] = (rxq.size() == 0);
        r[5] = (rxq.size() >= int'(m_rxthr));
        r[6] = (rxq.size() == 16);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic check_status(input string req);
        logic [31:0] d;
        logic [31:0] e;
        e = exp_raw();
        bus_rd(4'd6, d);
        chk(req, d, e);
        bus_rd(4'd7, d);
        chk(req, d, e & m_mask);
        chk(req, {31'd0, irq}, {31'd0, |(e & m_mask)});
    endtask

    task automatic op_txw(input logic [7:0] v);
        if (txq.size() == 16) m_sticky[3] = 1'b1;
        else txq.push_back(v);
        bus_wr(4'd1, {24'd0, v});
    endtask

    task automatic op_txpop();
        if (txq.size() > 0) begin
            chk("R2 tx order", {24'd0, tx_byte}, txq[0]);
            void'(txq.pop_front());
        end
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic op_rxpush(input logic [7:0] v);
        if (rxq.size() < 16) rxq.push_back(v);
        rx_push = 1'b1; rx_byte = v;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic op_rxrd();
        logic [31:0] d;
        bus_rd(4'd2, d);
        if (rxq.size() > 0) begin
            chk("R2 rx order", {24'd0, d[7:0]}, rxq[0]);
            void'(rxq.pop_front());
        end
    endtask

    task automatic op_evt(input logic [31:0] v);
        m_sticky = m_sticky | (v & ENG);
        eng_evt = v;
        tick();
        eng_evt = '0;
    endtask

    task automatic op_clr(input logic [31:0] v);
        m_sticky = m_sticky & ~(v & CLR);
        bus_wr(4'd8, v);
    endtask

    task automatic op_mask(input logic [31:0] v);
        m_mask = v & 32'h1FFF_FFFF;
        bus_wr(4'd5, v);
    endtask

    task automatic op_thr(input bit is_tx, input logic [31:0] v);
        if (is_tx) begin m_txthr = v[3:0]; bus_wr(4'd3, v); end
        else       begin m_rxthr = v[3:0]; bus_wr(4'd4, v); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h0000_5EED));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        bus_rd(4'd6, d); chk("R1 raw", d, 32'h0000_0033);
        bus_rd(4'd5, d); chk("R1 mask", d, 32'h0);
        bus_rd(4'd0, d); chk("R1 ctrl", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R6 threshold width, R10 mask reserved bits
        op_thr(1'b1, 32'hFFFF_FFFF);
        bus_rd(4'd3, d); chk("R6 tx thr", d, 32'h0000_000F);
        op_thr(1'b0, 32'h0000_0019);
        bus_rd(4'd4, d); chk("R6 rx thr", d, 32'h0000_0009);
        op_mask(32'hFFFF_FFFF);
        bus_rd(4'd5, d); chk("R10 mask", d, 32'h1FFF_FFFF);
        check_status("R10 masked");

        // R3 R7: fill, overrun, contents kept
        op_thr(1'b1, 32'd0);
        for (int i = 0; i < 16; i++) op_txw(8'(8'h40 + i));
        check_status("R3 tx full");
        op_txw(8'hEE);
        check_status("R7 overrun");
        for (int i = 0; i < 16; i++) op_txpop();
        check_status("R3 tx empty again");

        // R4 nearly empty boundary
        op_thr(1'b1, 32'd3);
        for (int i = 0; i < 3; i++) op_txw(8'(i));
        check_status("R4 level equals threshold");
        op_txw(8'h77);
        check_status("R4 level above threshold");

        // R5 nearly full boundary, R3 rx full
        op_thr(1'b0, 32'd5);
        for (int i = 0; i < 4; i++) op_rxpush(8'(8'h90 + i));
        check_status("R5 below threshold");
        op_rxpush(8'h94);
        check_status("R5 at threshold");
        for (int i = 0; i < 12; i++) op_rxpush(8'(8'hA0 + i));
        check_status("R3 rx full");

        // R8 event filtering and stickiness
        op_evt(~ENG);
        check_status("R8 ignored positions");
        op_evt(32'h0100_0000);
        tick();
        check_status("R8 sticky hold");
        op_evt(ENG);
        check_status("R8 all events");

        // R9 clear affects sticky only; set wins over clear
        op_clr(32'hFFFF_FFFF);
        check_status("R9 clear all");
        m_sticky[19] = 1'b1;
        eng_evt = 32'h0008_0000;
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h0008_0000;
        tick();
        reg_wr = 1'b0; eng_evt = '0;
        check_status("R9 set wins");

        // R11 R12 transmit flush
        bus_wr(4'd1, 32'h0);
        if (txq.size() < 16) txq.push_back(0);
        txq.delete();
        bus_wr(4'd0, 32'h0000_0080);
        for (int k = 0; k < 4; k++) begin
            if (k == 1) begin
                bus_rd(4'd6, d); chk("R12 tx level zero", {31'd0, d[0]}, 32'd1);
            end else begin
                bus_rd(4'd0, d); chk("R11 tx flush busy", d, 32'h0000_0080);
            end
        end
        bus_rd(4'd0, d); chk("R11 tx flush done", d, 32'h0);
        check_status("R12 tx after flush");

        // R11 R12 receive flush with pushes ignored
        bus_wr(4'd0, 32'h0000_0100);
        rxq.delete();
        rx_push = 1'b1; rx_byte = 8'h5A;
        tick(); tick();
        rx_push = 1'b0;
        tick(); tick();
        bus_rd(4'd0, d); chk("R11 rx flush done", d, 32'h0);
        check_status("R12 rx pushes ignored");

        // random mix
        for (int it = 0; it < 500; it++) begin
            int unsigned sel;
            sel = $urandom_range(0, 99);
            if (sel < 30)      op_txw(8'($urandom()));
            else if (sel < 45) op_txpop();
            else if (sel < 70) op_rxpush(8'($urandom()));
            else if (sel < 82) op_rxrd();
            else if (sel < 87) op_evt($urandom());
            else if (sel < 91) op_clr($urandom());
            else if (sel < 94) op_mask($urandom());
            else               op_thr(sel[0], $urandom());
            check_status("R2-mix R3 R4 R5 R8 R9 R10 random");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule